// File: doc/BRIEF.md
# Self-Test Diagnostic Error Gating

This block watches groups of diagnostic status lines, such as timing-loss and out-of-tolerance flags. There is one group for the multiplexer channel side and one for the demultiplexer channel side. A status line sits high while its channel is healthy. Each line is compared with the self-test level. During self-test the upstream channel cards invert their healthy level to low. The comparison keeps the no-fault reading unchanged in both modes, so a healthy channel never reads as a fault in either mode.

Each group merges its lines into one summary. While the summary is active, a saturating event counter advances once per clock. A detector flag latches once the counter reaches a threshold. Both the counter and the flag are held cleared in two cases. The first is while the group's disable switch is on. The second is a short window after self-test is entered, which is timed by a shift register that fills with ones. The disable switch also masks the group's lines and silences the group's priority encoder. The encoder reports the lowest-numbered faulting line.

Top module: `diag_gate_top`

## Requirements
- R1: While reset is active and right after it is released, every group's count (`err_cnt_o`) and detector flag (`fault_o`) read 0.
- R2: A line reads as faulting when its level equals `selftest_i`. So a low line is a fault in normal mode and a high line is a fault in self-test. With every line at its healthy level, counts stay 0 in both modes.
- R3: While at least one unmasked line of a group is faulting, its count rises by 1 on each rising clock edge and saturates at 2^CNT_W-1 (15 by default).
- R4: The detector flag sets on the edge where the count reaches THRESHOLD (8 by default). It stays set after the faults go away, until the group is cleared.
- R5: On each edge where `selftest_i` is high, a register of HOLD_STAGES stages (4 by default) shifts in a 1. The register is emptied on any edge where `selftest_i` is low. On every edge where `selftest_i` is high and the last stage is still 0, the count and the flag are cleared. Counting therefore resumes on the fifth edge after self-test entry, and re-entry clears a latched flag.
- R6: While a group's disable bit is high, the count and flag are cleared on every edge and its line faults are ignored.
- R7: `err_code_o` for a group gives the index of its lowest-numbered faulting line, with `err_code_vld_o` = 1. With no faulting line, both read 0. The output is combinational from the inputs.
- R8: While a group's disable bit is high, its code and valid outputs are 0.
- R9: Groups are independent. Group g uses lines `stat_i[g*NUM_LINES +: NUM_LINES]`, disable bit g and the field `[g*W +: W]` of each per-group bus. Group 0 is the multiplexer side and group 1 is the demultiplexer side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| selftest_i | input | 1 | Self-test level, high = self-test, already synchronous |
| grp_dis_i | input | NUM_GROUPS | Per-group disable switch, high = disabled |
| stat_i | input | NUM_GROUPS*NUM_LINES | Diagnostic status lines, grouped per R9 |
| err_cnt_o | output | NUM_GROUPS*CNT_W | Per-group saturating event count |
| fault_o | output | NUM_GROUPS | Per-group latched detector flag |
| err_code_o | output | NUM_GROUPS*IDX_W | Per-group lowest faulting line index |
| err_code_vld_o | output | NUM_GROUPS | Per-group code valid |

## Verification
The bench uses the default parameters: two groups of four lines, a 4-bit counter, a threshold of 8 and a four-stage hold register. With these values the threshold crossing, counter saturation and the full self-test hold window can each be reached in a few tens of cycles. Four lines are enough to show lowest-index priority among several faulting lines, while the other group runs a different pattern to show the groups do not interact.

// File: rtl/diag_gate_pkg.sv
package diag_gate_pkg;
  localparam int unsigned GRP_MUX   = 0;
  localparam int unsigned GRP_DEMUX = 1;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/diag_delay_en.sv
module diag_delay_en #(
  parameter int unsigned STAGES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic st_i,
  output logic hold_o
);
  localparam logic [STAGES-1:0] ONE = STAGES'(1);

  logic [STAGES-1:0] sr_q, sr_d;

  always_comb begin
    if (st_i) sr_d = (sr_q << 1) | ONE;
    else      sr_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= sr_d;
  end

  assign hold_o = st_i & ~sr_q[STAGES-1];
endmodule

// File: rtl/diag_err_det.sv
module diag_err_det #(
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned THRESHOLD = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_ni,
  input  logic             hit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] THR     = CNT_W'(THRESHOLD);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = !clr_ni || (hit_i && (cnt_q != CNT_MAX));
    if (!clr_ni) cnt_d = '0;
    else         cnt_d = cnt_q + CNT_W'(1);
    flag_d = clr_ni && (flag_q || ((cnt_en ? cnt_d : cnt_q) >= THR));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/diag_prio_enc.sv
module diag_prio_enc #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = 2
) (
  input  logic [N-1:0]  req_i,
  input  logic          inhibit_i,
  output logic [IW-1:0] code_o,
  output logic          vld_o
);
  always_comb begin
    code_o = '0;
    vld_o  = 1'b0;
    if (!inhibit_i) begin
      for (int i = N - 1; i >= 0; i--) begin
        if (req_i[i]) begin
          code_o = IW'(i);
          vld_o  = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/diag_group.sv
module diag_group #(
  parameter int unsigned NUM_LINES   = 4,
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned THRESHOLD   = 8,
  parameter int unsigned HOLD_STAGES = 4,
  parameter int unsigned IW          = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 st_i,
  input  logic                 dis_i,
  input  logic [NUM_LINES-1:0] stat_i,
  output logic [CNT_W-1:0]     cnt_o,
  output logic                 flag_o,
  output logic [IW-1:0]        code_o,
  output logic                 vld_o
);
  logic [NUM_LINES-1:0] line_flt, masked;
  logic                 summary, hold, clr_n;

  // A line is faulting when it sits at the same level as the self-test control
  assign line_flt = ~(stat_i ^ {NUM_LINES{st_i}});
  assign masked   = line_flt & ~{NUM_LINES{dis_i}};
  assign summary  = |masked;
  assign clr_n    = ~(dis_i | hold);

  diag_delay_en #(.STAGES(HOLD_STAGES)) u_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .st_i  (st_i),
    .hold_o(hold)
  );

  diag_err_det #(.CNT_W(CNT_W), .THRESHOLD(THRESHOLD)) u_det (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_ni(clr_n),
    .hit_i (summary),
    .cnt_o (cnt_o),
    .flag_o(flag_o)
  );

  diag_prio_enc #(.N(NUM_LINES), .IW(IW)) u_enc (
    .req_i    (masked),
    .inhibit_i(dis_i),
    .code_o   (code_o),
    .vld_o    (vld_o)
  );
endmodule

// File: rtl/diag_gate_top.sv
module diag_gate_top import diag_gate_pkg::*; #(
  parameter  int unsigned NUM_GROUPS  = 2,
  parameter  int unsigned NUM_LINES   = 4,
  parameter  int unsigned CNT_W       = 4,
  parameter  int unsigned THRESHOLD   = 8,
  parameter  int unsigned HOLD_STAGES = 4,
  localparam int unsigned IDX_W       = idx_w(NUM_LINES)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            selftest_i,
  input  logic [NUM_GROUPS-1:0]           grp_dis_i,
  input  logic [NUM_GROUPS*NUM_LINES-1:0] stat_i,
  output logic [NUM_GROUPS*CNT_W-1:0]     err_cnt_o,
  output logic [NUM_GROUPS-1:0]           fault_o,
  output logic [NUM_GROUPS*IDX_W-1:0]     err_code_o,
  output logic [NUM_GROUPS-1:0]           err_code_vld_o
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    diag_group #(
      .NUM_LINES  (NUM_LINES),
      .CNT_W      (CNT_W),
      .THRESHOLD  (THRESHOLD),
      .HOLD_STAGES(HOLD_STAGES),
      .IW         (IDX_W)
    ) u_grp (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .st_i  (selftest_i),
      .dis_i (grp_dis_i[g]),
      .stat_i(stat_i[g*NUM_LINES +: NUM_LINES]),
      .cnt_o (err_cnt_o[g*CNT_W +: CNT_W]),
      .flag_o(fault_o[g]),
      .code_o(err_code_o[g*IDX_W +: IDX_W]),
      .vld_o (err_code_vld_o[g])
    );
  end
endmodule

// File: rtl/diag_gate_chk.sv
module diag_gate_chk #(
  parameter int unsigned NUM_GROUPS = 2,
  parameter int unsigned CNT_W      = 4,
  parameter int unsigned THRESHOLD  = 8,
  parameter int unsigned IDX_W      = 2
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        selftest_i,
  input logic [NUM_GROUPS-1:0]       grp_dis_i,
  input logic [NUM_GROUPS*CNT_W-1:0] err_cnt_o,
  input logic [NUM_GROUPS-1:0]       fault_o,
  input logic [NUM_GROUPS*IDX_W-1:0] err_code_o,
  input logic [NUM_GROUPS-1:0]       err_code_vld_o
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
    assert_dis_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grp_dis_i[g] |=> (err_cnt_o[g*CNT_W +: CNT_W] == '0) && !fault_o[g]);

    assert_dis_silences_enc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grp_dis_i[g] |-> !err_code_vld_o[g] && (err_code_o[g*IDX_W +: IDX_W] == '0));

    assert_entry_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(selftest_i) |=> (err_cnt_o[g*CNT_W +: CNT_W] == '0) && !fault_o[g]);

    assert_cnt_no_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (err_cnt_o[g*CNT_W +: CNT_W] >= $past(err_cnt_o[g*CNT_W +: CNT_W]))
               || (err_cnt_o[g*CNT_W +: CNT_W] == '0));

    assert_flag_at_thr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(fault_o[g]) |-> (err_cnt_o[g*CNT_W +: CNT_W] >= CNT_W'(THRESHOLD)));
  end
endmodule

bind diag_gate_top diag_gate_chk #(
  .NUM_GROUPS(NUM_GROUPS),
  .CNT_W     (CNT_W),
  .THRESHOLD (THRESHOLD),
  .IDX_W     (IDX_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .selftest_i    (selftest_i),
  .grp_dis_i     (grp_dis_i),
  .err_cnt_o     (err_cnt_o),
  .fault_o       (fault_o),
  .err_code_o    (err_code_o),
  .err_code_vld_o(err_code_vld_o)
);

// File: tb/diag_gate_top_tb_top.sv
module diag_gate_top_tb_top;
  localparam int NG = 2;
  localparam int NL = 4;
  localparam int CW = 4;
  localparam int IW = 2;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               st;
  logic [NG-1:0]      dis;
  logic [NG*NL-1:0]   stat;
  logic [NG*CW-1:0]   cnt;
  logic [NG-1:0]      flt;
  logic [NG*IW-1:0]   code;
  logic [NG-1:0]      vld;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  diag_gate_top dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .selftest_i    (st),
    .grp_dis_i     (dis),
    .stat_i        (stat),
    .err_cnt_o     (cnt),
    .fault_o       (flt),
    .err_code_o    (code),
    .err_code_vld_o(vld)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int gcnt(input int g);
    return int'(cnt[g*CW +: CW]);
  endfunction

  function automatic int gcode(input int g);
    return int'(code[g*IW +: IW]);
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; st = 1'b0; dis = '0; stat = '1;
    tick(3);
    check("R1 count g0 in reset", gcnt(0), 0);
    rst_n = 1'b1;
    tick(1);
    check("R1 count g1 after reset", gcnt(1), 0);
    check("R1 flags after reset", int'(flt), 0);
  endtask

  task automatic t_normal_healthy();
    stat = '1;
    tick(5);
    check("R2 normal healthy count g0", gcnt(0), 0);
    check("R7 no fault valid", int'(vld), 0);
  endtask

  task automatic t_count();
    stat[3:0] = 4'b1011; #1;
    check("R7 single line code", gcode(0), 2);
    check("R7 single line valid", int'(vld[0]), 1);
    stat[3:0] = 4'b0101; #1;
    check("R7 lowest of lines 1,3", gcode(0), 1);
    tick(7);
    check("R3 count after 7", gcnt(0), 7);
    check("R4 flag below threshold", int'(flt[0]), 0);
    tick(1);
    check("R4 count at threshold", gcnt(0), 8);
    check("R4 flag at threshold", int'(flt[0]), 1);
    check("R9 other group idle", gcnt(1), 0);
    stat[3:0] = 4'b1111;
    tick(3);
    check("R4 count held without faults", gcnt(0), 8);
    check("R4 flag sticky", int'(flt[0]), 1);
    stat[3:0] = 4'b1110;
    tick(7);
    check("R3 count reaches max", gcnt(0), 15);
    tick(2);
    check("R3 count saturates", gcnt(0), 15);
  endtask

  task automatic t_disable();
    dis[0] = 1'b1;
    stat[7:4] = 4'b0111; #1;
    check("R8 disabled code", gcode(0), 0);
    check("R8 disabled valid", int'(vld[0]), 0);
    check("R7 group1 code line3", gcode(1), 3);
    tick(1);
    check("R6 disable clears count", gcnt(0), 0);
    check("R6 disable clears flag", int'(flt[0]), 0);
    tick(5);
    check("R6 faults ignored while disabled", gcnt(0), 0);
    check("R9 group1 counts alone", gcnt(1), 6);
    dis[0] = 1'b0; stat[3:0] = 4'b1111; dis[1] = 1'b1;
    tick(1);
    check("R6 group1 cleared", gcnt(1), 0);
    dis[1] = 1'b0; stat[7:4] = 4'b1111;
    tick(1);
  endtask

  task automatic t_selftest();
    st = 1'b1; stat = '0;
    tick(10);
    check("R2 self-test healthy (low) count g0", gcnt(0), 0);
    check("R2 self-test healthy count g1", gcnt(1), 0);
    st = 1'b0; stat = '1;
    tick(2);
    st = 1'b1; stat[3:0] = 4'b1111; stat[7:4] = 4'b0000; #1;
    check("R7 self-test high line code", gcode(0), 0);
    check("R2 self-test high is fault", int'(vld[0]), 1);
    tick(4);
    check("R5 hold window count", gcnt(0), 0);
    tick(1);
    check("R5 counting resumes", gcnt(0), 1);
    tick(7);
    check("R5 count after window", gcnt(0), 8);
    check("R4 flag in self-test", int'(flt[0]), 1);
    check("R9 group1 quiet in self-test", gcnt(1), 0);
    st = 1'b0; stat = '1;
    tick(1);
    check("R4 flag kept on exit", int'(flt[0]), 1);
    st = 1'b1; stat[3:0] = 4'b1111; stat[7:4] = 4'b0000;
    tick(1);
    check("R5 re-entry clears flag", int'(flt[0]), 0);
    check("R5 re-entry clears count", gcnt(0), 0);
  endtask

  initial begin
    t_reset();
    t_normal_healthy();
    t_count();
    t_disable();
    t_selftest();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule